// File: doc/BRIEF.md
# Dual-Channel PWM Fan Driver with Frequency Divider

This block generates two independent fan PWM outputs from a system clock. Each channel has three pieces of state reached through a byte-wide register port: an 8-bit duty setting, an 8-bit frequency divider, and a 2-bit base-rate code packed with the other channel's code into a shared selection byte. A prescaler turns the system clock into a slot tick for the chosen base rate. The divider stretches every slot, and a comparator drives the output high for the first `setting` slots of each 255-slot period.

Each channel also has a closed-loop input. While it is asserted, an external 8-bit duty value drives the channel and host writes to that channel's setting register are dropped. A read of a setting register returns the duty value that currently feeds the channel, so in closed-loop mode it returns the external value. Duty, divider and base code are taken in only at a period boundary, so a register write never cuts a pulse short. Channel 1 appears on `pwm_out[0]` and channel 2 on `pwm_out[1]`.

Top module: `fan_pwm_driver`

## Requirements
- R1: After reset, both setting registers read 00h, both divide registers read 01h, the base selection byte reads 00h and both outputs are low.
- R2: Register map: base selection byte at 20h (all 8 bits stored and read back; channel 1 code in bits 1:0, channel 2 code in bits 3:2); setting registers at 30h (channel 1) and 40h (channel 2); divide registers at 31h and 41h. A write is taken on a clock edge where `reg_we` is high. `reg_rdata` is combinational from `reg_addr`.
- R3: Base code 0 selects 26000 Hz, 1 selects 19531 Hz, 2 selects 4882 Hz and 3 selects 2441 Hz. The slot tick interval is round(CLK_HZ / (255 × f)) clocks, with a minimum of 1.
- R4: A PWM period is 255 × tick × divide clocks. The output is high for setting × tick × divide clocks of each period, starting at the period's first slot.
- R5: A setting of 00h keeps the output low and a setting of FFh keeps it high for the whole period.
- R6: A write of 00h to a divide register stores 01h.
- R7: While a channel's closed-loop input is high, host writes to its setting register are discarded, and the stored host value is unchanged when the input is released.
- R8: In closed-loop mode the channel's duty comes from its external duty input. A read of the setting register returns the duty value currently selected for that channel in either mode.
- R9: New duty, divide and base values take effect only at the start of the next PWM period. A write in mid-period leaves the current pulse unchanged.
- R10: A read of any unmapped address returns 00h, and a write to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| loop_active | input | 2 | Closed-loop active, bit 0 for channel 1, bit 1 for channel 2 |
| loop_duty_a | input | 8 | External duty for channel 1 in closed-loop mode |
| loop_duty_b | input | 8 | External duty for channel 2 in closed-loop mode |
| pwm_out | output | 2 | PWM outputs, bit 0 for channel 1, bit 1 for channel 2 |

## Verification
On every cycle the assertions check the following: setting writes are dropped under closed-loop control, the stored divider is never zero, the latched duty moves only on a period boundary, a setting of 0 or 255 pins the output, a setting read mirrors the external duty in closed-loop mode, and unmapped reads return zero. Only the bench scenarios can show the timing results. These are the exact period and high-time lengths for each base code and divider, the placement of the two base codes in the shared byte, the survival of a pulse that is already running when its duty is rewritten, and the stored host setting reappearing once closed-loop control ends.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;

  typedef logic [1:0][7:0] byte_pair_t;

  localparam logic [7:0] ADDR_BASE_SEL = 8'h20;

  function automatic logic [7:0] set_addr(input int unsigned ch);
    return 8'h30 + 8'(16 * ch);
  endfunction

  function automatic logic [7:0] div_addr(input int unsigned ch);
    return 8'h31 + 8'(16 * ch);
  endfunction

  function automatic int unsigned base_hz(input logic [1:0] code);
    case (code)
      2'd0:    return 26000;
      2'd1:    return 19531;
      2'd2:    return 4882;
      default: return 2441;
    endcase
  endfunction

  // Clocks per duty slot: rounded quotient, never below one.
  function automatic int unsigned tick_clocks(input int unsigned clk_hz, input logic [1:0] code);
    int unsigned den;
    int unsigned q;
    den = 255 * base_hz(code);
    q = (clk_hz + den / 2) / den;
    return (q == 0) ? 1 : q;
  endfunction

endpackage

// File: rtl/fan_pwm_rst_sync.sv
module fan_pwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/fan_pwm_regs.sv
module fan_pwm_regs
  import fan_pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  input  logic [1:0] loop_active,
  input  byte_pair_t loop_duty,
  output byte_pair_t host_set,
  output byte_pair_t div_val,
  output byte_pair_t drive_val,
  output logic [3:0] code_pair,
  output logic [7:0] rdata
);
  byte_pair_t set_q, set_n;
  byte_pair_t div_q, div_n;
  logic [7:0] base_q, base_n;

  // Next-state for the register file
  always_comb begin
    set_n  = set_q;
    div_n  = div_q;
    base_n = base_q;
    if (we) begin
      if (addr == ADDR_BASE_SEL) base_n = wdata;
      for (int g = 0; g < 2; g++) begin
        if (addr == set_addr(g) && !loop_active[g]) set_n[g] = wdata;
        if (addr == div_addr(g)) div_n[g] = (wdata == 8'h00) ? 8'h01 : wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q  <= '0;
      div_q  <= {8'h01, 8'h01};
      base_q <= 8'h00;
    end else begin
      set_q  <= set_n;
      div_q  <= div_n;
      base_q <= base_n;
    end
  end

  // Duty source selection per channel
  always_comb begin
    for (int g = 0; g < 2; g++) begin
      drive_val[g] = loop_active[g] ? loop_duty[g] : set_q[g];
    end
  end

  // Read mux
  always_comb begin
    rdata = 8'h00;
    if (addr == ADDR_BASE_SEL) rdata = base_q;
    for (int g = 0; g < 2; g++) begin
      if (addr == set_addr(g)) rdata = drive_val[g];
      if (addr == div_addr(g)) rdata = div_q[g];
    end
  end

  assign host_set  = set_q;
  assign div_val   = div_q;
  assign code_pair = base_q[3:0];
endmodule

// File: rtl/fan_pwm_channel.sv
module fan_pwm_channel
  import fan_pwm_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] duty_in,
  input  logic [7:0] div_in,
  input  logic [1:0] code_in,
  output logic [7:0] duty_act,
  output logic       period_start,
  output logic       pwm
);
  localparam int unsigned T0 = tick_clocks(CLK_HZ, 2'd0);
  localparam int unsigned T1 = tick_clocks(CLK_HZ, 2'd1);
  localparam int unsigned T2 = tick_clocks(CLK_HZ, 2'd2);
  localparam int unsigned T3 = tick_clocks(CLK_HZ, 2'd3);
  localparam int unsigned TA = (T0 > T1) ? T0 : T1;
  localparam int unsigned TB = (T2 > T3) ? T2 : T3;
  localparam int unsigned TMAX = (TA > TB) ? TA : TB;
  localparam int unsigned PW = (TMAX > 1) ? $clog2(TMAX) : 1;
  localparam logic [7:0] LAST_SLOT = 8'd254;

  logic [PW-1:0] pre_q, pre_n, tick_lim;
  logic [7:0]    divc_q, divc_n;
  logic [7:0]    slot_q, slot_n;
  logic [7:0]    duty_q, duty_n;
  logic [7:0]    divl_q, divl_n;
  logic [1:0]    code_q, code_n;
  logic          tick, adv, pstart;

  always_comb begin
    case (code_q)
      2'd0:    tick_lim = PW'(T0 - 1);
      2'd1:    tick_lim = PW'(T1 - 1);
      2'd2:    tick_lim = PW'(T2 - 1);
      default: tick_lim = PW'(T3 - 1);
    endcase
  end

  assign tick   = (pre_q == tick_lim);
  assign adv    = tick && (divc_q == divl_q - 8'd1);
  assign pstart = adv && (slot_q == LAST_SLOT);

  // Next-state: prescaler, divide stage, slot counter, boundary latch
  always_comb begin
    pre_n  = tick ? '0 : pre_q + PW'(1);
    divc_n = divc_q;
    slot_n = slot_q;
    duty_n = duty_q;
    divl_n = divl_q;
    code_n = code_q;
    if (tick) divc_n = adv ? 8'd0 : divc_q + 8'd1;
    if (adv)  slot_n = (slot_q == LAST_SLOT) ? 8'd0 : slot_q + 8'd1;
    if (pstart) begin
      duty_n = duty_in;
      divl_n = (div_in == 8'h00) ? 8'h01 : div_in;
      code_n = code_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      divc_q <= 8'd0;
      slot_q <= 8'd0;
      duty_q <= 8'h00;
      divl_q <= 8'h01;
      code_q <= 2'd0;
    end else begin
      pre_q  <= pre_n;
      divc_q <= divc_n;
      slot_q <= slot_n;
      duty_q <= duty_n;
      divl_q <= divl_n;
      code_q <= code_n;
    end
  end

  assign pwm          = (slot_q < duty_q);
  assign duty_act     = duty_q;
  assign period_start = pstart;
endmodule

// File: rtl/fan_pwm_driver.sv
module fan_pwm_driver
  import fan_pwm_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_we,
  output logic [7:0] reg_rdata,
  input  logic [1:0] loop_active,
  input  logic [7:0] loop_duty_a,
  input  logic [7:0] loop_duty_b,
  output logic [1:0] pwm_out
);
  logic       rst_n_s;
  byte_pair_t loop_duty;
  byte_pair_t host_set;
  byte_pair_t div_val;
  byte_pair_t drive_val;
  byte_pair_t duty_act;
  logic [3:0] code_pair;
  logic [1:0] period_start;

  assign loop_duty = {loop_duty_b, loop_duty_a};

  fan_pwm_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  fan_pwm_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .we          (reg_we),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .loop_active (loop_active),
    .loop_duty   (loop_duty),
    .host_set    (host_set),
    .div_val     (div_val),
    .drive_val   (drive_val),
    .code_pair   (code_pair),
    .rdata       (reg_rdata)
  );

  for (genvar g = 0; g < 2; g++) begin : g_ch
    fan_pwm_channel #(.CLK_HZ(CLK_HZ)) u_ch (
      .clk          (clk),
      .rst_n        (rst_n_s),
      .duty_in      (drive_val[g]),
      .div_in       (div_val[g]),
      .code_in      (code_pair[2*g +: 2]),
      .duty_act     (duty_act[g]),
      .period_start (period_start[g]),
      .pwm          (pwm_out[g])
    );
  end
endmodule

// File: rtl/fan_pwm_checker.sv
module fan_pwm_checker (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_we,
  input logic [7:0]      reg_addr,
  input logic [7:0]      reg_rdata,
  input logic [1:0]      loop_active,
  input logic [7:0]      loop_duty_a,
  input logic [7:0]      loop_duty_b,
  input logic [1:0][7:0] host_set,
  input logic [1:0][7:0] div_val,
  input logic [1:0][7:0] duty_act,
  input logic [1:0]      period_start,
  input logic [1:0]      pwm_out
);
  logic mapped;
  assign mapped = (reg_addr == 8'h20) || (reg_addr == 8'h30) || (reg_addr == 8'h31) ||
                  (reg_addr == 8'h40) || (reg_addr == 8'h41);

  a_r7_lock_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_active[0] && reg_we && reg_addr == 8'h30) |=> (host_set[0] == $past(host_set[0])));
  a_r7_lock_ch2: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_active[1] && reg_we && reg_addr == 8'h40) |=> (host_set[1] == $past(host_set[1])));

  a_r6_div_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (div_val[0] != 8'h00) && (div_val[1] != 8'h00));

  a_r9_hold_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start[0] |=> $stable(duty_act[0]));
  a_r9_hold_ch2: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start[1] |=> $stable(duty_act[1]));

  a_r5_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act[0] == 8'h00) |-> !pwm_out[0]);
  a_r5_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act[1] == 8'hFF) |-> pwm_out[1]);

  a_r8_live_read: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_active[0] && reg_addr == 8'h30) |-> (reg_rdata == loop_duty_a));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (reg_rdata == 8'h00));
endmodule

bind fan_pwm_driver fan_pwm_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n_s),
  .reg_we       (reg_we),
  .reg_addr     (reg_addr),
  .reg_rdata    (reg_rdata),
  .loop_active  (loop_active),
  .loop_duty_a  (loop_duty_a),
  .loop_duty_b  (loop_duty_b),
  .host_set     (host_set),
  .div_val      (div_val),
  .duty_act     (duty_act),
  .period_start (period_start),
  .pwm_out      (pwm_out)
);

// File: tb/fan_pwm_driver_bench.sv
module fan_pwm_driver_bench;
  localparam int CLK = 20_000_000;

  logic       clk;
  logic       rst_n;
  logic [7:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_we;
  logic [7:0] reg_rdata;
  logic [1:0] loop_active;
  logic [7:0] loop_duty_a;
  logic [7:0] loop_duty_b;
  logic [1:0] pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int cur_code[2];
  int cur_div[2];
  int cur_duty[2];

  fan_pwm_driver #(.CLK_HZ(CLK)) u_fan_pwm_driver (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .loop_active(loop_active),
    .loop_duty_a(loop_duty_a), .loop_duty_b(loop_duty_b), .pwm_out(pwm_out)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tdiv(input int code);
    int hz;
    int q;
    case (code)
      0: hz = 26000;
      1: hz = 19531;
      2: hz = 4882;
      default: hz = 2441;
    endcase
    q = (CLK + (255 * hz) / 2) / (255 * hz);
    return (q < 1) ? 1 : q;
  endfunction

  function automatic int per(input int code, input int dv);
    return 255 * tdiv(code) * dv;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic measure(input int ch, input int duty, input int code, input int dv);
    int p;
    int hi;
    int exp_hi;
    int n;
    bit prev;
    bit found;
    p = per(code, dv);
    hi = 0;
    exp_hi = duty * tdiv(code) * dv;
    repeat (p) begin
      @(negedge clk);
      if (pwm_out[ch]) hi++;
    end
    if (duty == 0 || duty == 255) chk(hi == exp_hi, "R5 pinned output high count", hi, exp_hi);
    else chk(hi == exp_hi, "R3 R4 high time", hi, exp_hi);
    if (duty > 0 && duty < 255) begin
      found = 0;
      @(negedge clk);
      prev = pwm_out[ch];
      for (int i = 0; i < 2 * p && !found; i++) begin
        @(negedge clk);
        if (!prev && pwm_out[ch]) found = 1;
        prev = pwm_out[ch];
      end
      n = 0;
      if (found) begin
        for (int i = 0; i < 2 * p; i++) begin
          @(negedge clk);
          n++;
          if (!prev && pwm_out[ch]) break;
          prev = pwm_out[ch];
        end
      end
      chk(n == p, "R3 R4 period length", n, p);
    end
  endtask

  task automatic cfg(input int c1, input int d1, input int s1, input int c2, input int d2, input int s2);
    int old;
    int e1;
    int e2;
    old = per(cur_code[0], cur_div[0]);
    if (per(cur_code[1], cur_div[1]) > old) old = per(cur_code[1], cur_div[1]);
    wr(8'h20, 8'({c2[1:0], c1[1:0]}));
    wr(8'h31, 8'(d1));
    wr(8'h41, 8'(d2));
    wr(8'h30, 8'(s1));
    wr(8'h40, 8'(s2));
    e1 = (d1 == 0) ? 1 : d1;
    e2 = (d2 == 0) ? 1 : d2;
    repeat (old + 20) @(negedge clk);
    cur_code[0] = c1; cur_div[0] = e1; cur_duty[0] = s1;
    cur_code[1] = c2; cur_div[1] = e2; cur_duty[1] = s2;
    fork
      measure(0, s1, c1, e1);
      measure(1, s2, c2, e2);
    join
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    int v;
    int hi;
    bit prev;
    void'($urandom(32'd1234));
    rst_n = 0; reg_addr = 0; reg_wdata = 0; reg_we = 0;
    loop_active = 0; loop_duty_a = 0; loop_duty_b = 0;
    cur_code = '{0, 0}; cur_div = '{1, 1}; cur_duty = '{0, 0};
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(pwm_out == 2'b00, "R1 outputs low", pwm_out, 0);
    rd(8'h30, v); chk(v == 0, "R1 setting 1 reset", v, 0);
    rd(8'h40, v); chk(v == 0, "R1 setting 2 reset", v, 0);
    rd(8'h31, v); chk(v == 1, "R1 divide 1 reset", v, 1);
    rd(8'h41, v); chk(v == 1, "R1 divide 2 reset", v, 1);
    rd(8'h20, v); chk(v == 0, "R1 base byte reset", v, 0);

    // R2 R3 R4 base code placement and timing
    cfg(0, 1, 128, 1, 2, 64);
    rd(8'h20, v); chk(v == 8'h04, "R2 base byte readback", v, 8'h04);
    rd(8'h41, v); chk(v == 2, "R2 divide 2 readback", v, 2);
    rd(8'h30, v); chk(v == 128, "R2 setting 1 readback", v, 128);

    // R5 pinned outputs
    cfg(0, 1, 255, 0, 1, 0);

    // R6 divide zero becomes one
    cfg(2, 0, 100, 0, 3, 200);
    rd(8'h31, v); chk(v == 1, "R6 divide zero stored as one", v, 1);

    // R9 mid-period write does not cut the running pulse
    cfg(0, 1, 128, 0, 1, 0);
    @(negedge clk);
    prev = pwm_out[0];
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!prev && pwm_out[0]) break;
      prev = pwm_out[0];
    end
    wr(8'h30, 8'h00);
    hi = 0;
    repeat (300) begin
      @(negedge clk);
      if (pwm_out[0]) hi++;
    end
    chk(hi == 300, "R9 pulse kept after rewrite", hi, 300);
    repeat (per(0, 1) + 20) @(negedge clk);
    cur_duty[0] = 0;
    measure(0, 0, 0, 1);

    // R7 R8 closed-loop control on channel 2
    cfg(0, 1, 10, 0, 1, 50);
    @(negedge clk);
    loop_active = 2'b10; loop_duty_b = 8'h80; loop_duty_a = 8'h33;
    rd(8'h40, v); chk(v == 8'h80, "R8 read returns external duty", v, 8'h80);
    rd(8'h30, v); chk(v == 10, "R8 open-loop channel reads host value", v, 10);
    wr(8'h40, 8'h11);
    repeat (per(0, 1) + 20) @(negedge clk);
    measure(1, 128, 0, 1);
    loop_active = 2'b00;
    rd(8'h40, v); chk(v == 50, "R7 host value kept through lock", v, 50);

    // R10 unmapped address
    wr(8'h32, 8'hAA);
    wr(8'h00, 8'h55);
    rd(8'h32, v); chk(v == 0, "R10 unmapped reads zero", v, 0);
    rd(8'hFF, v); chk(v == 0, "R10 unmapped reads zero", v, 0);
    rd(8'h30, v); chk(v == 10, "R10 setting 1 untouched", v, 10);
    rd(8'h31, v); chk(v == 1, "R10 divide 1 untouched", v, 1);
    rd(8'h20, v); chk(v == 0, "R10 base byte untouched", v, 0);

    // Random configurations, R3 R4
    for (int k = 0; k < 5; k++) begin
      int c1;
      int c2;
      int d1;
      int d2;
      c1 = $urandom_range(0, 2);
      c2 = $urandom_range(0, 2);
      d1 = (c1 == 2) ? 1 : $urandom_range(1, 4);
      d2 = (c2 == 2) ? 1 : $urandom_range(1, 4);
      cfg(c1, d1, $urandom_range(0, 255), c2, d2, $urandom_range(0, 255));
    end

    // Slowest base code, R3
    cfg(3, 1, 77, 0, 1, 1);

    done = 1;
    finish_run();
  end
endmodule